// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Register Bank

This block is the digital front end of an eight-channel, 13-bit voltage DAC. A host writes codes over a parallel bus. The bus carries a 13-bit data word, a 3-bit channel address, an active-low select strobe, an active-low write strobe, an active-low load strobe and an active-low clear. Each channel holds two code registers. The staging register takes bus data while select and write are both low. The output register copies the staging register while load is low. One load therefore updates every channel in the same cycle.

The transparent-latch behaviour is emulated synchronously. The four strobes pass through a synchronizer chain. The data, address and format bits pass through a delay chain of the same depth, so that they stay aligned with the strobes. Every register stage then samples on each clock edge while its enable condition holds.

When select, write and load are all low together, the addressed channel's output code follows the bus directly. Clear leaves both register stages untouched and raises a per-channel force-to-ground flag. A one-cycle deglitch-enable pulse marks each falling edge of load. Two protocol checks raise flags: an address that moves during a write window, and a load released too soon after write rises.

Top module: `dac_bank_front`

## Requirements
- R1: Address value k (binary, 0 to 7) selects channel k: 0 is the first channel and 7 is the last. Channel k's code appears on `code_out[k*13 +: 13]`.
- R2: The addressed staging register takes the bus word while select and write are both low. It keeps its value while either strobe is high, whatever the bus does.
- R3: While load is low, every output register copies its staging register. While load is high, every output code holds.
- R4: With select, write and load all low, the addressed channel's output code tracks the bus word cycle by cycle. The other channels keep their codes.
- R5: While clear is low, every bit of `gnd_force` is 1. Clear changes no stored code, and the same codes are present after clear returns high, when `gnd_force` is 0 again.
- R6: With `twos_mode` high, the stored code is the bus word with bit 12 inverted (two's complement plus 4096). With `twos_mode` low, the stored code is the bus word unchanged.
- R7: Each falling edge of load produces exactly one single-cycle pulse on `deglitch_pulse`.
- R8: If the address changes between two consecutive cycles in which select and write are both low, `addr_err` pulses for one cycle. A steady address raises no pulse.
- R9: If load is low while write is low, and load then returns high fewer than LD_HOLD_CYC (default 4) cycles after write rises, `ld_hold_err` pulses for one cycle. Holding load for LD_HOLD_CYC cycles or more raises no pulse.
- R10: After reset, every staging and output register holds 0x1000 (mid-scale), and all flags are 0.
- R11: `chan_upd[k]` pulses for one cycle exactly when channel k's output code changes. A load that leaves a code the same produces no pulse.
- R12: A bus change reaches a register stage on the third rising edge after it is applied: two synchronizer edges, then the register edge. A write that is already stored reaches the output one edge after load is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_data | input | 13 | Host data word |
| bus_addr | input | 3 | Channel address |
| cs_n | input | 1 | Active-low select strobe |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low load strobe (all channels) |
| clr_n | input | 1 | Active-low clear (force to ground) |
| twos_mode | input | 1 | 1: bus word is two's complement |
| code_out | output | 104 | Eight 13-bit output codes, channel k at bits k*13 upward |
| gnd_force | output | 8 | Per-channel force-to-ground flag |
| chan_upd | output | 8 | Per-channel output-code change pulse |
| deglitch_pulse | output | 1 | Deglitch-enable pulse on load falling edge |
| addr_err | output | 1 | Address moved during a write window |
| ld_hold_err | output | 1 | Load released too early after write |

## Verification
A strobe or bus change applied just after a falling clock edge reaches the register outputs after the third rising edge. The bench therefore samples codes three falling edges after each stimulus. In one case it also samples two falling edges after, to confirm that the code has not moved yet. `gnd_force` follows clear one edge sooner, so it has settled by the same sampling point. The pulse outputs (`deglitch_pulse`, `chan_upd`, `addr_err`, `ld_hold_err`) are counted 2 ns after each rising edge, and the counts are compared once the three-edge window has passed.

// File: rtl/dacb_pkg.sv
package dacb_pkg;

   // Control strobes, all active low, carried through one synchronizer.
   typedef struct packed {
      logic cs_n;
      logic wr_n;
      logic ld_n;
      logic clr_n;
   } dacb_ctrl_t;

   localparam int CTRL_W = $bits(dacb_ctrl_t);

endpackage

// File: rtl/dacb_sync.sv
module dacb_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= RST_VAL;
            end else if (s == 0) begin
               chain[s] <= d;
            end else begin
               chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dacb_chan.sv
module dacb_chan #(
   parameter int DW = 13,
   parameter logic [DW-1:0] RST_CODE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_sel,
   input  logic          ld_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] in_q,
   output logic [DW-1:0] out_q,
   output logic          upd
);

   logic [DW-1:0] out_nxt;

   // Both stages open together: the bus word bypasses the staging register.
   always_comb begin
      if (ld_en) out_nxt = wr_sel ? wdata : in_q;
      else       out_nxt = out_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= RST_CODE;
         out_q <= RST_CODE;
         upd   <= 1'b0;
      end else begin
         if (wr_sel) in_q <= wdata;
         out_q <= out_nxt;
         upd   <= (out_nxt != out_q);
      end
   end

endmodule

// File: rtl/dacb_proto.sv
module dacb_proto #(
   parameter int AW = 3,
   parameter int LD_HOLD_CYC = 4,
   localparam int CW = $clog2(LD_HOLD_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_s,
   input  logic          ld_s,
   input  logic [AW-1:0] addr_s,
   output logic          deglitch,
   output logic          addr_err,
   output logic          hold_err
);

   logic          wr_en_q;
   logic [AW-1:0] addr_q;
   logic          ld_q;
   logic          armed;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q  <= 1'b0;
         addr_q   <= '0;
         ld_q     <= 1'b1;
         deglitch <= 1'b0;
         addr_err <= 1'b0;
         armed    <= 1'b0;
         cnt      <= '0;
         hold_err <= 1'b0;
      end else begin
         wr_en_q  <= wr_en;
         addr_q   <= addr_s;
         ld_q     <= ld_s;
         deglitch <= ld_q & ~ld_s;
         addr_err <= wr_en & wr_en_q & (addr_s != addr_q);
         hold_err <= 1'b0;
         if (ld_s) begin
            hold_err <= armed & wr_s;
            armed    <= 1'b0;
            cnt      <= '0;
         end else if (!wr_s) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (armed) begin
            if (cnt == CW'(LD_HOLD_CYC - 1)) begin
               armed <= 1'b0;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dac_bank_front.sv
module dac_bank_front #(
   parameter int DW = 13,
   parameter int NCH = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LD_HOLD_CYC = 4,
   localparam int AW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     bus_data,
   input  logic [AW-1:0]     bus_addr,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              ld_n,
   input  logic              clr_n,
   input  logic              twos_mode,
   output logic [NCH*DW-1:0] code_out,
   output logic [NCH-1:0]    gnd_force,
   output logic [NCH-1:0]    chan_upd,
   output logic              deglitch_pulse,
   output logic              addr_err,
   output logic              ld_hold_err
);
   import dacb_pkg::*;

   localparam int PW = DW + AW + 1;
   localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);

   generate
      if (DW < 2)            begin : g_bad_dw   $error("DW must be at least 2"); end
      if (NCH < 2)           begin : g_bad_nch  $error("NCH must be at least 2"); end
      if (NCH != (1 << AW))  begin : g_bad_pow  $error("NCH must be a power of two"); end
      if (SYNC_STAGES < 2)   begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (LD_HOLD_CYC < 1)   begin : g_bad_hold $error("LD_HOLD_CYC must be at least 1"); end
   endgenerate

   dacb_ctrl_t ctrl_raw, ctrl_s;
   logic [PW-1:0] pay_raw, pay_s;
   logic [DW-1:0] data_s, wdata;
   logic [AW-1:0] addr_s;
   logic          twos_s;
   logic          wr_en, ld_en;
   logic [NCH*DW-1:0] in_flat;

   assign ctrl_raw = '{cs_n: cs_n, wr_n: wr_n, ld_n: ld_n, clr_n: clr_n};
   assign pay_raw  = {twos_mode, bus_addr, bus_data};

   dacb_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ctrl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
   );

   // Payload delayed by the same depth so it stays aligned with the strobes.
   dacb_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pay_dly (
      .clk(clk), .rst_n(rst_n), .d(pay_raw), .q(pay_s)
   );

   assign {twos_s, addr_s, data_s} = pay_s;
   assign wr_en = ~ctrl_s.cs_n & ~ctrl_s.wr_n;
   assign ld_en = ~ctrl_s.ld_n;
   assign wdata = twos_s ? {~data_s[DW-1], data_s[DW-2:0]} : data_s;
   assign gnd_force = {NCH{~ctrl_s.clr_n}};

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic sel;
         assign sel = wr_en && (addr_s == AW'(i));
         dacb_chan #(.DW(DW), .RST_CODE(MID_CODE)) u_chan (
            .clk(clk), .rst_n(rst_n), .wr_sel(sel), .ld_en(ld_en), .wdata(wdata),
            .in_q(in_flat[i*DW +: DW]), .out_q(code_out[i*DW +: DW]), .upd(chan_upd[i])
         );
      end
   endgenerate

   dacb_proto #(.AW(AW), .LD_HOLD_CYC(LD_HOLD_CYC)) u_proto (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_s(ctrl_s.wr_n), .ld_s(ctrl_s.ld_n),
      .addr_s(addr_s), .deglitch(deglitch_pulse), .addr_err(addr_err), .hold_err(ld_hold_err)
   );

endmodule

// File: rtl/dacb_checker.sv
module dacb_checker #(
   parameter int DW = 13,
   parameter int NCH = 8,
   parameter int AW = 3,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              ld_en,
   input logic [AW-1:0]     addr_s,
   input logic [DW-1:0]     wdata,
   input logic [NCH*DW-1:0] in_flat,
   input logic [NCH*DW-1:0] code_out,
   input logic [NCH-1:0]    chan_upd,
   input logic [NCH-1:0]    gnd_force,
   input logic              clr_n,
   input logic              deglitch_pulse,
   input logic              ld_hold_err
);

   // Reference delay for the clear input, independent of the design's chain.
   logic [SYNC_STAGES-1:0] clr_sh;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clr_sh <= '1;
      else        clr_sh <= {clr_sh[SYNC_STAGES-2:0], clr_n};
   end

   p_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(in_flat));

   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(code_out));

   p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !wr_en) |=> (code_out == $past(in_flat)));

   p_clear_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gnd_force == {NCH{~clr_sh[SYNC_STAGES-1]}});

   p_dg_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      deglitch_pulse |=> !deglitch_pulse);

   p_hold_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hold_err |=> !ld_hold_err);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_pc
         p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr_s == AW'(i)) |=> (in_flat[i*DW +: DW] == $past(wdata)));

         p_upd_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
            chan_upd[i] |-> (code_out[i*DW +: DW] != $past(code_out[i*DW +: DW])));

         p_no_upd_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_upd[i] |-> (code_out[i*DW +: DW] == $past(code_out[i*DW +: DW])));
      end
   endgenerate

endmodule

bind dac_bank_front dacb_checker #(
   .DW(DW), .NCH(NCH), .AW(AW), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ld_en(ld_en), .addr_s(addr_s),
   .wdata(wdata), .in_flat(in_flat), .code_out(code_out), .chan_upd(chan_upd),
   .gnd_force(gnd_force), .clr_n(clr_n), .deglitch_pulse(deglitch_pulse),
   .ld_hold_err(ld_hold_err)
);

// File: tb/tb_dac_bank_front.sv
`timescale 1ns/1ps
module tb_dac_bank_front;

   localparam int DW = 13;
   localparam int NCH = 8;
   localparam int AW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DW-1:0]     bus_data = '0;
   logic [AW-1:0]     bus_addr = '0;
   logic              cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
   logic              twos_mode = 1'b0;
   logic [NCH*DW-1:0] code_out;
   logic [NCH-1:0]    gnd_force, chan_upd;
   logic              deglitch_pulse, addr_err, ld_hold_err;

   int total = 0, bad = 0;
   int dg_cnt = 0, aerr_cnt = 0, herr_cnt = 0, upd_cnt = 0;
   logic [DW-1:0] exp_in [NCH];
   logic [DW-1:0] exp_out [NCH];

   always #4 clk = ~clk;

   dac_bank_front dut (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
      .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n), .twos_mode(twos_mode),
      .code_out(code_out), .gnd_force(gnd_force), .chan_upd(chan_upd),
      .deglitch_pulse(deglitch_pulse), .addr_err(addr_err), .ld_hold_err(ld_hold_err)
   );

   // Pulse counters sampled 2 ns after each rising edge.
   always begin
      @(posedge clk);
      #2;
      if (rst_n) begin
         dg_cnt   += int'(deglitch_pulse);
         aerr_cnt += int'(addr_err);
         herr_cnt += int'(ld_hold_err);
         upd_cnt  += $countones(chan_upd);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] code_of(input int k);
      return code_out[k*DW +: DW];
   endfunction

   task automatic check_all_codes(input string req);
      for (int k = 0; k < NCH; k++)
         chk(code_of(k) == exp_out[k], req, int'(code_of(k)), int'(exp_out[k]));
   endtask

   task automatic wr_ch(input int a, input logic [DW-1:0] d, input logic [DW-1:0] stored);
      bus_addr = AW'(a); bus_data = d; cs_n = 1'b0; wr_n = 1'b0;
      tick(1);
      cs_n = 1'b1; wr_n = 1'b1;
      tick(1);
      exp_in[a] = stored;
   endtask

   task automatic ld_pulse();
      ld_n = 1'b0;
      tick(1);
      ld_n = 1'b1;
      tick(3);
      for (int k = 0; k < NCH; k++) exp_out[k] = exp_in[k];
   endtask

   task automatic t_reset();
      tick(3);
      for (int k = 0; k < NCH; k++) begin
         exp_in[k] = 13'h1000; exp_out[k] = 13'h1000;
      end
      check_all_codes("R10 reset code");
      chk(gnd_force == '0, "R10 gnd_force", int'(gnd_force), 0);
      chk(chan_upd == '0 && !deglitch_pulse && !addr_err && !ld_hold_err,
          "R10 flags", int'({chan_upd, deglitch_pulse, addr_err, ld_hold_err}), 0);
   endtask

   task automatic t_write_load();
      int u0 = upd_cnt;
      int a0 = aerr_cnt;
      for (int k = 0; k < NCH; k++) wr_ch(k, DW'(13'h0100 + k * 13'h0211), DW'(13'h0100 + k * 13'h0211));
      tick(3);
      check_all_codes("R3 hold while load high");
      chk(aerr_cnt == a0, "R8 steady address no error", aerr_cnt - a0, 0);
      ld_pulse();
      check_all_codes("R1 R3 broadcast load per address");
      chk(upd_cnt - u0 == NCH, "R11 one pulse per changed channel", upd_cnt - u0, NCH);
   endtask

   task automatic t_reload_same();
      int u0 = upd_cnt;
      ld_pulse();
      check_all_codes("R11 unchanged codes");
      chk(upd_cnt == u0, "R11 no pulse on same-code load", upd_cnt - u0, 0);
   endtask

   task automatic t_input_hold();
      int u0 = upd_cnt;
      wr_ch(2, 13'h1ABC, 13'h1ABC);
      bus_data = 13'h0555;
      bus_addr = 3'd2;
      tick(3);
      ld_pulse();
      chk(code_of(2) == 13'h1ABC, "R2 staging holds with strobes high", int'(code_of(2)), 'h1ABC);
      chk(upd_cnt - u0 == 1, "R11 single channel change", upd_cnt - u0, 1);
   endtask

   task automatic t_direct();
      int h0 = herr_cnt;
      ld_n = 1'b0;
      tick(3);
      for (int k = 0; k < NCH; k++) exp_out[k] = exp_in[k];
      bus_addr = 3'd6; bus_data = 13'h1234; cs_n = 1'b0; wr_n = 1'b0;
      tick(3);
      chk(code_of(6) == 13'h1234, "R4 direct path", int'(code_of(6)), 'h1234);
      bus_data = 13'h0777;
      tick(2);
      chk(code_of(6) == 13'h1234, "R12 not yet after two edges", int'(code_of(6)), 'h1234);
      tick(1);
      chk(code_of(6) == 13'h0777, "R4 R12 tracks bus on third edge", int'(code_of(6)), 'h0777);
      chk(code_of(5) == exp_out[5], "R4 other channel steady", int'(code_of(5)), int'(exp_out[5]));
      cs_n = 1'b1; wr_n = 1'b1;
      tick(6);
      ld_n = 1'b1;
      tick(3);
      exp_in[6] = 13'h0777; exp_out[6] = 13'h0777;
      chk(herr_cnt == h0, "R9 long enough hold no error", herr_cnt - h0, 0);
      check_all_codes("R4 codes after direct mode");
   endtask

   task automatic t_twos();
      twos_mode = 1'b1;
      wr_ch(0, 13'h0000, 13'h1000);
      wr_ch(1, 13'h1FFF, 13'h0FFF);
      wr_ch(3, 13'h0FFF, 13'h1FFF);
      twos_mode = 1'b0;
      wr_ch(4, 13'h0FFF, 13'h0FFF);
      ld_pulse();
      check_all_codes("R6 format conversion");
   endtask

   task automatic t_clear();
      clr_n = 1'b0;
      tick(3);
      chk(gnd_force == '1, "R5 flag set in clear", int'(gnd_force), 'hFF);
      check_all_codes("R5 codes kept in clear");
      clr_n = 1'b1;
      tick(3);
      chk(gnd_force == '0, "R5 flag released", int'(gnd_force), 0);
      check_all_codes("R5 codes reappear");
   endtask

   task automatic t_deglitch();
      int d0 = dg_cnt;
      ld_pulse();
      ld_pulse();
      chk(dg_cnt - d0 == 2, "R7 one pulse per load fall", dg_cnt - d0, 2);
   endtask

   task automatic t_addr_err();
      int a0 = aerr_cnt;
      bus_addr = 3'd2; bus_data = 13'h0ACE; cs_n = 1'b0; wr_n = 1'b0;
      tick(1);
      bus_addr = 3'd3;
      tick(1);
      cs_n = 1'b1; wr_n = 1'b1;
      tick(3);
      exp_in[2] = 13'h0ACE; exp_in[3] = 13'h0ACE;
      chk(aerr_cnt - a0 == 1, "R8 address moved in window", aerr_cnt - a0, 1);
      check_all_codes("R8 outputs held with load high");
   endtask

   task automatic t_hold_err();
      int h0 = herr_cnt;
      bus_addr = 3'd4; bus_data = 13'h0444; cs_n = 1'b0; wr_n = 1'b0;
      tick(1);
      ld_n = 1'b0;
      tick(1);
      cs_n = 1'b1; wr_n = 1'b1;
      tick(1);
      ld_n = 1'b1;
      tick(3);
      exp_in[4] = 13'h0444;
      for (int k = 0; k < NCH; k++) exp_out[k] = exp_in[k];
      chk(herr_cnt - h0 == 1, "R9 early load release", herr_cnt - h0, 1);
      chk(code_of(4) == 13'h0444, "R4 direct write landed", int'(code_of(4)), 'h0444);
      check_all_codes("R3 pending inputs moved on load");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      t_reset();
      t_write_load();
      t_reload_same();
      t_input_hold();
      t_direct();
      t_twos();
      t_clear();
      t_deglitch();
      t_addr_err();
      t_hold_err();
      tick(2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule